// File: doc/BRIEF.md
# Serial DAC Write Controller

This block is the host-side driver for a 12-bit voltage DAC that takes its code over a three-wire serial link plus a load strobe and an asynchronous clear. Logic inside the chip hands a code over a valid/ready handshake. The controller then selects the converter and presents the code one bit at a time, most significant bit first. The converter captures each bit on a rising serial clock. After the last bit the controller pulses the load strobe so that the converter's output register takes the new word. A separate request produces a timed clear pulse, which forces the converter's output register to zero.

The converter's output register is a latch that is transparent while its load input is low. For that reason the controller keeps the load strobe high for the whole shift phase and lowers it only after the last bit has been captured. Every phase length is counted in system clock cycles. Each count is rounded up at elaboration from a nanosecond minimum and the system clock period, so the same RTL meets the converter's pulse-width, setup and hold limits at any system clock rate.

Top module: `dac_serial_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, dac_cs_n, dac_sclk, dac_ld_n and dac_clr_n are all high and wr_ready is high.
- R2: A code is taken only on a clock edge where wr_valid and wr_ready are both high. wr_ready is low from that edge until the transfer, including its load pulse and recovery, has completed. Codes offered while wr_ready is low produce no activity on the serial pins.
- R3: After acceptance, dac_cs_n is low with dac_sclk high for ceil(30 ns / Tclk) cycles before the first falling serial clock. During those cycles dac_sdi already carries bit 11 of the code.
- R4: The code is sent on dac_sdi as 12 bits, bit 11 first and bit 0 last. dac_sdi changes only together with a falling dac_sclk and is stable across each rising edge.
- R5: Each serial clock low phase lasts ceil(30 ns / Tclk) cycles and each high phase lasts ceil(30 ns / Tclk) cycles.
- R6: After the last rising serial clock, dac_cs_n stays low and dac_sclk high for max(ceil(20 ns / Tclk), ceil(15 ns / Tclk)) cycles.
- R7: dac_ld_n is never low while dac_cs_n is low. After the tail, dac_cs_n rises and dac_ld_n goes low for ceil(20 ns / Tclk) cycles.
- R8: After dac_ld_n rises, all pins stay idle for ceil(10 ns / Tclk) cycles before wr_ready returns high.
- R9: A clear request taken while the controller is idle drives dac_clr_n low for ceil(30 ns / Tclk) cycles, with dac_cs_n and dac_ld_n high, and then returns to idle.
- R10: A clear request that arrives during a transfer, or on the same edge that a code is accepted, is held pending. Its clear pulse starts right after that transfer's recovery.
- R11: dac_sclk is high whenever dac_cs_n is high.
- R12: wr_ready is low while a clear is pending or its pulse is in progress, so a pending clear always runs before the next code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A code is offered |
| wr_data | input | 12 | Code to send, straight binary |
| wr_ready | output | 1 | Controller can take a code |
| clr_req | input | 1 | One-cycle request for a clear pulse |
| dac_cs_n | output | 1 | Converter select, active low |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdi | output | 1 | Serial data, most significant bit first |
| dac_ld_n | output | 1 | Load strobe, active low |
| dac_clr_n | output | 1 | Clear strobe, active low |

## Verification
The transfer is exercised with all-ones, all-zeros and the codes on either side of midscale, which expose a wrong bit order or a missing bit. Alternating patterns expose a slipped or doubled shift. In a long run with wr_valid held high and the code changing every cycle, the only codes that appear on the wire must be the ones present on acceptance edges, which exposes early acceptance or a late drop of ready. Clears are tried from idle, in the middle of a transfer, on the same edge as an accepted code, and during another clear's pulse. These separate immediate, deferred and lost clears, and they also check that the clear takes priority over a code waiting on the handshake.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_LOAD,
        ST_REC,
        ST_CLR
    } wr_state_e;

    typedef struct packed {
        wr_state_e st;
        logic      cs_n;
        logic      sclk;
        logic      ld_n;
        logic      clr_n;
        logic      ready;
        logic      pend;
    } ctl_t;

    // cycles of period_ps needed to cover ns, never fewer than one
    function automatic int ns_to_cyc(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacw_phase_timer.sv
module dacw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R5: a phase is never cut short by a reload
    a_r5_phase_complete: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done);

endmodule

// File: rtl/dacw_shifter.sv
module dacw_shifter #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              shift,
    output logic              msb,
    output logic              last
);

    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [DATA_W-1:0] sh_d, sh_q;
    logic [BIT_W-1:0]  left_d, left_q;

    always_comb begin
        sh_d   = sh_q;
        left_d = left_q;
        if (load) begin
            sh_d   = load_data;
            left_d = BIT_W'(DATA_W - 1);
        end else if (shift) begin
            sh_d   = {sh_q[DATA_W-2:0], 1'b0};
            left_d = left_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else begin
            sh_q   <= sh_d;
            left_q <= left_d;
        end
    end

    assign msb  = sh_q[DATA_W-1];
    assign last = (left_q == '0);

    // R4: never shift beyond the final bit of a word
    a_r4_no_extra_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !last);

endmodule

// File: rtl/dac_serial_writer.sv
module dac_serial_writer #(
    parameter int DATA_W        = 12,
    parameter int CLK_PERIOD_PS = 10000,
    parameter int T_SCLK_HI_NS  = 30,
    parameter int T_SCLK_LO_NS  = 30,
    parameter int T_SEL_NS      = 30,
    parameter int T_DESEL_NS    = 20,
    parameter int T_LD_SU_NS    = 15,
    parameter int T_LD_PW_NS    = 20,
    parameter int T_LD_REC_NS   = 10,
    parameter int T_CLR_PW_NS   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              clr_req,
    output logic              dac_cs_n,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_ld_n,
    output logic              dac_clr_n
);
    import dacw_pkg::*;

    localparam int C_HI   = ns_to_cyc(T_SCLK_HI_NS, CLK_PERIOD_PS);
    localparam int C_LO   = ns_to_cyc(T_SCLK_LO_NS, CLK_PERIOD_PS);
    localparam int C_SEL  = ns_to_cyc(T_SEL_NS,     CLK_PERIOD_PS);
    localparam int C_TAIL = imax(ns_to_cyc(T_DESEL_NS, CLK_PERIOD_PS),
                                 ns_to_cyc(T_LD_SU_NS, CLK_PERIOD_PS));
    localparam int C_LDW  = ns_to_cyc(T_LD_PW_NS,   CLK_PERIOD_PS);
    localparam int C_REC  = ns_to_cyc(T_LD_REC_NS,  CLK_PERIOD_PS);
    localparam int C_CLR  = ns_to_cyc(T_CLR_PW_NS,  CLK_PERIOD_PS);
    localparam int C_MAX  = imax(imax(imax(C_HI, C_LO), imax(C_SEL, C_TAIL)),
                                 imax(imax(C_LDW, C_REC), C_CLR));
    localparam int CNT_W  = $clog2(C_MAX + 1);

    ctl_t             ctl_d, ctl_q;
    logic             t_load, t_done;
    logic [CNT_W-1:0] t_val;
    logic             sh_load, sh_shift, sh_msb, sh_last;

    dacw_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    dacw_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .load_data (wr_data),
        .shift     (sh_shift),
        .msb       (sh_msb),
        .last      (sh_last)
    );

    always_comb begin
        ctl_d    = ctl_q;
        t_load   = 1'b0;
        t_val    = '0;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        if (ctl_q.st != ST_IDLE)
            ctl_d.pend = ctl_q.pend | clr_req;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (ctl_q.pend) begin
                    ctl_d.st    = ST_CLR;
                    ctl_d.clr_n = 1'b0;
                    ctl_d.pend  = 1'b0;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(C_CLR - 1);
                end else if (wr_valid && ctl_q.ready) begin
                    ctl_d.st   = ST_SEL;
                    ctl_d.cs_n = 1'b0;
                    ctl_d.pend = clr_req;
                    sh_load    = 1'b1;
                    t_load     = 1'b1;
                    t_val      = CNT_W'(C_SEL - 1);
                end else if (clr_req) begin
                    ctl_d.st    = ST_CLR;
                    ctl_d.clr_n = 1'b0;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(C_CLR - 1);
                end
            end
            ST_SEL: if (t_done) begin
                ctl_d.st   = ST_LOW;
                ctl_d.sclk = 1'b0;
                t_load     = 1'b1;
                t_val      = CNT_W'(C_LO - 1);
            end
            ST_LOW: if (t_done) begin
                ctl_d.st   = ST_HIGH;
                ctl_d.sclk = 1'b1;
                t_load     = 1'b1;
                t_val      = CNT_W'(C_HI - 1);
            end
            ST_HIGH: if (t_done) begin
                t_load = 1'b1;
                if (sh_last) begin
                    ctl_d.st = ST_TAIL;
                    t_val    = CNT_W'(C_TAIL - 1);
                end else begin
                    ctl_d.st   = ST_LOW;
                    ctl_d.sclk = 1'b0;
                    sh_shift   = 1'b1;
                    t_val      = CNT_W'(C_LO - 1);
                end
            end
            ST_TAIL: if (t_done) begin
                ctl_d.st   = ST_LOAD;
                ctl_d.cs_n = 1'b1;
                ctl_d.ld_n = 1'b0;
                t_load     = 1'b1;
                t_val      = CNT_W'(C_LDW - 1);
            end
            ST_LOAD: if (t_done) begin
                ctl_d.st   = ST_REC;
                ctl_d.ld_n = 1'b1;
                t_load     = 1'b1;
                t_val      = CNT_W'(C_REC - 1);
            end
            ST_REC: if (t_done) ctl_d.st = ST_IDLE;
            ST_CLR: if (t_done) begin
                ctl_d.st    = ST_IDLE;
                ctl_d.clr_n = 1'b1;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
        ctl_d.ready = (ctl_d.st == ST_IDLE) && !ctl_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, cs_n: 1'b1, sclk: 1'b1, ld_n: 1'b1,
                       clr_n: 1'b1, ready: 1'b1, pend: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_ready  = ctl_q.ready;
    assign dac_cs_n  = ctl_q.cs_n;
    assign dac_sclk  = ctl_q.sclk;
    assign dac_ld_n  = ctl_q.ld_n;
    assign dac_clr_n = ctl_q.clr_n;
    assign dac_sdi   = sh_msb;

    // R7: latch stays closed while the word is being shifted
    a_r7_ld_high_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_ld_n);

    // R11: serial clock parks high when deselected
    a_r11_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> dac_sclk);

    // R9: clear pulse never overlaps a transfer or load
    a_r9_clr_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_cs_n && dac_ld_n));

    // R2: no handshake while the link is busy
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n || !dac_ld_n || !dac_clr_n) |-> !wr_ready);

    // R4: data steady across each rising serial clock
    a_r4_sdi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_sclk) |-> $stable(dac_sdi));

    // R4: data held through the high phase while selected
    a_r4_sdi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && $past(!dac_cs_n) && dac_sclk && $past(dac_sclk)) |-> $stable(dac_sdi));

endmodule

// File: tb/tb_dac_serial_writer.sv
module tb_dac_serial_writer;

    localparam int PERIOD_PS = 4000;

    typedef struct {
        logic  cs_n;
        logic  sclk;
        logic  ld_n;
        logic  clr_n;
        logic  sdi;
        logic  chk;
        string req;
    } exp_t;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
        return (c < 1) ? 1 : c;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_data = '0;
    logic        clr_req = 1'b0;
    logic        wr_ready, dac_cs_n, dac_sclk, dac_sdi, dac_ld_n, dac_clr_n;

    int   vectors = 0;
    int   errors  = 0;
    exp_t exp_q[$];
    bit   pend = 1'b0;

    always #2ns clk = ~clk;

    dac_serial_writer #(.CLK_PERIOD_PS(PERIOD_PS)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .wr_ready  (wr_ready),
        .clr_req   (clr_req),
        .dac_cs_n  (dac_cs_n),
        .dac_sclk  (dac_sclk),
        .dac_sdi   (dac_sdi),
        .dac_ld_n  (dac_ld_n),
        .dac_clr_n (dac_clr_n)
    );

    task automatic push(input logic cs, input logic sc, input logic ld, input logic cl,
                        input logic sd, input logic ck, input string r, input int n);
        exp_t e;
        e.cs_n = cs; e.sclk = sc; e.ld_n = ld; e.clr_n = cl;
        e.sdi = sd; e.chk = ck; e.req = r;
        for (int k = 0; k < n; k++) exp_q.push_back(e);
    endtask

    task automatic plan_write(input logic [11:0] d);
        push(0, 1, 1, 1, d[11], 1, "R3", cyc(30));
        for (int b = 11; b >= 0; b--) begin
            push(0, 0, 1, 1, d[b], 1, "R4", cyc(30));
            push(0, 1, 1, 1, d[b], 1, "R5", cyc(30));
        end
        push(0, 1, 1, 1, d[0], 1, "R6", (cyc(20) > cyc(15)) ? cyc(20) : cyc(15));
        push(1, 1, 0, 1, 0, 0, "R7", cyc(20));
        push(1, 1, 1, 1, 0, 0, "R8", cyc(10));
    endtask

    task automatic plan_clear(input string r);
        push(1, 1, 1, 0, 0, 0, r, cyc(30));
    endtask

    // one system cycle: compare, then drive inputs for the next edge
    task automatic cycle(input logic v, input logic [11:0] d, input logic c);
        exp_t e;
        bit   idle_now, rdy_exp, bad;
        @(negedge clk);
        idle_now = (exp_q.size() == 0);
        if (idle_now) begin
            e.cs_n = 1; e.sclk = 1; e.ld_n = 1; e.clr_n = 1;
            e.sdi = 0; e.chk = 0; e.req = "R11";
        end else begin
            e = exp_q.pop_front();
        end
        rdy_exp = idle_now && !pend;
        vectors++;
        bad = (dac_cs_n !== e.cs_n) || (dac_sclk !== e.sclk) || (dac_ld_n !== e.ld_n) ||
              (dac_clr_n !== e.clr_n) || (e.chk && (dac_sdi !== e.sdi));
        if (bad) begin
            errors++;
            $display("FAIL %s: cs/sclk/ld/clr/sdi = %b%b%b%b%b expected %b%b%b%b%b",
                     e.req, dac_cs_n, dac_sclk, dac_ld_n, dac_clr_n, dac_sdi,
                     e.cs_n, e.sclk, e.ld_n, e.clr_n, e.sdi);
        end else if (wr_ready !== rdy_exp) begin
            errors++;
            $display("FAIL %s: wr_ready = %b expected %b", pend ? "R12" : "R2",
                     wr_ready, rdy_exp);
        end
        wr_valid = v;
        wr_data  = d;
        clr_req  = c;
        if (idle_now) begin
            if (pend) begin
                plan_clear("R10");
                pend = 1'b0;
            end else if (v && rdy_exp) begin
                plan_write(d);
                pend = c;
            end else if (c) begin
                plan_clear("R9");
            end
        end else begin
            pend = pend | c;
        end
    endtask

    task automatic drain();
        do cycle(0, '0, 0); while (exp_q.size() != 0 || pend);
        cycle(0, '0, 0);
    endtask

    task automatic send(input logic [11:0] d);
        cycle(1, d, 0);
        drain();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        // R1: idle levels during reset
        repeat (3) @(negedge clk);
        vectors++;
        if ({dac_cs_n, dac_sclk, dac_ld_n, dac_clr_n, wr_ready} !== 5'b11111) begin
            errors++;
            $display("FAIL R1: pins/ready = %b expected 11111",
                     {dac_cs_n, dac_sclk, dac_ld_n, dac_clr_n, wr_ready});
        end
        rst_n = 1'b1;
        repeat (3) cycle(0, '0, 0);

        // R3 R4 R5 R6 R7 R8: single transfers with distinct patterns
        send(12'hFFF);
        send(12'h000);
        send(12'h800);
        send(12'h7FF);
        send(12'hA5A);
        send(12'h5A5);
        send(12'h001);

        // R2: valid held high, data changing every cycle
        for (int k = 0; k < 700; k++) cycle(1, 12'((k * 37 + 5) & 12'hFFF), 0);
        drain();

        // R9: clear from idle
        cycle(0, '0, 1);
        drain();

        // R10: clear in the middle of a transfer
        cycle(1, 12'hC3C, 0);
        repeat (60) cycle(0, '0, 0);
        cycle(0, '0, 1);
        drain();

        // R10: clear on the same edge as an accepted code
        cycle(1, 12'h3C3, 1);
        drain();

        // R9 R10: second request during a clear pulse
        cycle(0, '0, 1);
        repeat (3) cycle(0, '0, 0);
        cycle(0, '0, 1);
        drain();

        // R12: code waiting while a clear is pending
        cycle(1, 12'h0F0, 0);
        repeat (20) cycle(0, '0, 0);
        cycle(0, '0, 1);
        for (int k = 0; k < 400; k++) cycle(1, 12'h123, 0);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule